// File: doc/BRIEF.md
# Dual-Width Carry and Overflow Flag Unit

This unit is the add/subtract slice of a 64-bit fixed-point datapath. It computes one result per accepted operation: add, subtract-from (NOT A plus B plus carry), the add-minus-one and add-zero forms, negate, and a plain add that leaves the carry alone. It also keeps the status flags that these operations produce. A mode bit picks 64-bit or 32-bit semantics for the primary carry and overflow flags. A second pair of flags always describes the low 32-bit word, so software running in either mode can read both views.

The result and all five flags are registered. They are updated on the rising clock edge that accepts an operation. A clear strobe and a direct-load strobe act on the flag register. The clear strobe is the only way to drop the sticky summary-overflow flag.

Top module: `dwflag_unit`

## Requirements
- R1: While reset is asserted and right after it, `result` is zero and `ca`, `ca32`, `ov`, `ov32` and `so` are all 0.
- R2: An operation with `op_valid`=1 registers its `result` on the next edge, and `result` holds while `op_valid`=0. The `op_code` values are:

  | `op_code` | Result |
  |---|---|
  | 0 | A+B+cin |
  | 1 | ~A+B+cin |
  | 2 | A+all-ones+cin |
  | 3 | ~A+all-ones+cin |
  | 4 | A+cin |
  | 5 | ~A+cin |
  | 6 | ~A+1 (negate) |
  | 7 | A+B (no carry-in, carry flags untouched) |

- R3: For `op_code` 0 to 5 the carry-in is set by `cin_sel`: 0 gives 0, 1 gives 1, 2 gives the stored `ca`, and 3 gives 0.
- R4: In 64-bit mode (`mode64`=1), a carrying operation (`op_code` 0 to 5) loads `ca` with the carry out of bit 63.
- R5: In 32-bit mode `ca` gets the carry out of bit 31. In both modes `ca32` gets the carry out of bit 31.
- R6: `ca` and `ca32` are always written together. They are written only by `op_code` 0 to 5 or by the strobes; `op_code` 6 and 7 leave both unchanged.
- R7: With `oe`=1, `ov` gets signed overflow of the 64-bit result in 64-bit mode and of the low 32-bit result in 32-bit mode. `ov32` always gets low-word signed overflow, except as stated in R10.
- R8: With `oe`=0, an operation leaves `ov`, `ov32` and `so` unchanged.
- R9: `so` is set whenever `ov` is written as 1. It stays 1 through later operations and is cleared only by `flag_clr` (or a `flag_wr` that loads 0).
- R10: For negate with `oe`=1, `ov32` equals `ov`. An operand of 0x8000_0000_0000_0000 in 64-bit mode sets both flags. A low word of 0x8000_0000 in 32-bit mode sets both flags.
- R11: Strobe priority:
  - `flag_clr` zeroes all flags and overrides everything else.
  - Otherwise `flag_wr` loads `flag_wdata` (bit0 ca, bit1 ca32, bit2 ov, bit3 ov32, bit4 so) and overrides any flag update from an operation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept an operation this cycle |
| op_code | input | 3 | Operation select (see R2) |
| cin_sel | input | 2 | Carry-in source for op_code 0 to 5 |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| oe | input | 1 | Overflow-enable: allow the overflow flags to update |
| mode64 | input | 1 | 1 = 64-bit semantics, 0 = 32-bit semantics |
| flag_clr | input | 1 | Clear all flags |
| flag_wr | input | 1 | Load flags from flag_wdata |
| flag_wdata | input | 5 | Flag load value {so, ov32, ov, ca32, ca} |
| result | output | 64 | Registered result |
| ca | output | 1 | Primary carry, mode-dependent |
| ca32 | output | 1 | Low-word carry |
| ov | output | 1 | Primary overflow, mode-dependent |
| ov32 | output | 1 | Low-word overflow |
| so | output | 1 | Sticky summary overflow |

## Verification
The hardest cases to reach are those where the two flag pairs disagree. Examples are a carry out of bit 31 with no carry out of bit 63, or a 64-bit negate of 0x0000_0000_8000_0000, where the low word alone would overflow but `ov32` must follow `ov` and stay 0. The stimulus picks operands whose low and high words carry or overflow independently, and runs the same operand in both modes. It also drives operations in the same cycle as `flag_wr` or `flag_clr`, so the priority between an operation and the strobes can be seen at the flag outputs.

// File: rtl/dwflag_pkg.sv
package dwflag_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUBF  = 3'd1,
        OP_ADDM  = 3'd2,
        OP_SUBFM = 3'd3,
        OP_ADDZ  = 3'd4,
        OP_SUBFZ = 3'd5,
        OP_NEG   = 3'd6,
        OP_ADDNC = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_CA   = 2'd2,
        CIN_RSV  = 2'd3
    } cin_e;

    // bit0 ca, bit1 ca32, bit2 ov, bit3 ov32, bit4 so
    typedef struct packed {
        logic so;
        logic ov32;
        logic ov;
        logic ca32;
        logic ca;
    } flags_t;

endpackage

// File: rtl/dwflag_opsel.sv
module dwflag_opsel
    import dwflag_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  op_e               op,
    input  cin_e              csel,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              ca_q,
    output logic [DATA_W-1:0] a_eff,
    output logic [DATA_W-1:0] b_eff,
    output logic              cin,
    output logic              upd_carry,
    output logic              is_neg
);

    logic sel_cin;

    always_comb begin
        unique case (csel)
            CIN_ZERO: sel_cin = 1'b0;
            CIN_ONE:  sel_cin = 1'b1;
            CIN_CA:   sel_cin = ca_q;
            CIN_RSV:  sel_cin = 1'b0;
        endcase
    end

    always_comb begin
        a_eff     = a_in;
        b_eff     = b_in;
        cin       = sel_cin;
        upd_carry = 1'b1;
        is_neg    = 1'b0;
        unique case (op)
            OP_ADD:   begin a_eff = a_in;  b_eff = b_in;        end
            OP_SUBF:  begin a_eff = ~a_in; b_eff = b_in;        end
            OP_ADDM:  begin a_eff = a_in;  b_eff = '1;          end
            OP_SUBFM: begin a_eff = ~a_in; b_eff = '1;          end
            OP_ADDZ:  begin a_eff = a_in;  b_eff = '0;          end
            OP_SUBFZ: begin a_eff = ~a_in; b_eff = '0;          end
            OP_NEG: begin
                a_eff     = ~a_in;
                b_eff     = '0;
                cin       = 1'b1;
                upd_carry = 1'b0;
                is_neg    = 1'b1;
            end
            OP_ADDNC: begin
                a_eff     = a_in;
                b_eff     = b_in;
                cin       = 1'b0;
                upd_carry = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dwflag_adder.sv
module dwflag_adder #(
    parameter int DATA_W = 64,
    parameter int LO_W   = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              c_lo,
    output logic              c_hi,
    output logic              v_lo,
    output logic              v_hi
);

    localparam int HI_W = DATA_W - LO_W;

    logic [LO_W:0] lo_sum;
    logic [HI_W:0] hi_sum;

    // low word first; its carry feeds the high word
    assign lo_sum = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]}
                  + {{LO_W{1'b0}}, cin};
    assign hi_sum = {1'b0, a[DATA_W-1:LO_W]} + {1'b0, b[DATA_W-1:LO_W]}
                  + {{HI_W{1'b0}}, lo_sum[LO_W]};

    assign sum  = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
    assign c_lo = lo_sum[LO_W];
    assign c_hi = hi_sum[HI_W];

    assign v_lo = (a[LO_W-1] == b[LO_W-1]) && (sum[LO_W-1] != a[LO_W-1]);
    assign v_hi = (a[DATA_W-1] == b[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);

endmodule

// File: rtl/dwflag_regs.sv
module dwflag_regs
    import dwflag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   wr,
    input  flags_t wdata,
    input  logic   carry_we,
    input  logic   ca_nxt,
    input  logic   ca32_nxt,
    input  logic   ov_we,
    input  logic   ov_nxt,
    input  logic   ov32_nxt,
    output flags_t q
);

    flags_t d;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else if (wr) begin
            d = wdata;
        end else begin
            if (carry_we) begin
                d.ca   = ca_nxt;
                d.ca32 = ca32_nxt;
            end
            if (ov_we) begin
                d.ov   = ov_nxt;
                d.ov32 = ov32_nxt;
                d.so   = q.so | ov_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_carry_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr && !carry_we) |=> ($stable(q.ca) && $stable(q.ca32)));

    p_ov_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr && !ov_we) |=> ($stable(q.ov) && $stable(q.ov32) && $stable(q.so)));

    p_so_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.so && !clr && !wr) |=> q.so);

    p_so_on_ov_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr && ov_we && ov_nxt) |=> (q.so && q.ov));

    p_clr_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

endmodule

// File: rtl/dwflag_unit.sv
module dwflag_unit
    import dwflag_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LO_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        cin_sel,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              oe,
    input  logic              mode64,
    input  logic              flag_clr,
    input  logic              flag_wr,
    input  logic [4:0]        flag_wdata,
    output logic [DATA_W-1:0] result,
    output logic              ca,
    output logic              ca32,
    output logic              ov,
    output logic              ov32,
    output logic              so
);

    flags_t            fl_q;
    logic [DATA_W-1:0] a_eff, b_eff, sum;
    logic              cin, upd_carry, is_neg;
    logic              c_lo, c_hi, v_lo, v_hi;
    logic              ov_sel;

    dwflag_opsel #(.DATA_W(DATA_W)) u_sel (
        .op        (op_e'(op_code)),
        .csel      (cin_e'(cin_sel)),
        .a_in      (op_a),
        .b_in      (op_b),
        .ca_q      (fl_q.ca),
        .a_eff     (a_eff),
        .b_eff     (b_eff),
        .cin       (cin),
        .upd_carry (upd_carry),
        .is_neg    (is_neg)
    );

    dwflag_adder #(.DATA_W(DATA_W), .LO_W(LO_W)) u_add (
        .a    (a_eff),
        .b    (b_eff),
        .cin  (cin),
        .sum  (sum),
        .c_lo (c_lo),
        .c_hi (c_hi),
        .v_lo (v_lo),
        .v_hi (v_hi)
    );

    assign ov_sel = mode64 ? v_hi : v_lo;

    dwflag_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flag_clr),
        .wr       (flag_wr),
        .wdata    (flags_t'(flag_wdata)),
        .carry_we (op_valid && upd_carry),
        .ca_nxt   (mode64 ? c_hi : c_lo),
        .ca32_nxt (c_lo),
        .ov_we    (op_valid && oe),
        .ov_nxt   (ov_sel),
        .ov32_nxt (is_neg ? ov_sel : v_lo),
        .q        (fl_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (op_valid) result <= sum;
    end

    assign ca   = fl_q.ca;
    assign ca32 = fl_q.ca32;
    assign ov   = fl_q.ov;
    assign ov32 = fl_q.ov32;
    assign so   = fl_q.so;

    p_mode32_carry_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !mode64 && (op_code < 3'd6) && !flag_clr && !flag_wr)
        |=> (ca == ca32));

    p_neg_ov_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && oe && (op_code == 3'd6) && !flag_clr && !flag_wr)
        |=> (ov == ov32));

    p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(result));

endmodule

// File: tb/sim_dwflag_unit.sv
`timescale 1ns/1ps
module sim_dwflag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  cin_sel = '0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        oe = 1'b0, mode64 = 1'b1;
    logic        flag_clr = 1'b0, flag_wr = 1'b0;
    logic [4:0]  flag_wdata = '0;
    logic [63:0] result;
    logic        ca, ca32, ov, ov32, so;

    always #2 clk = ~clk;

    dwflag_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .cin_sel(cin_sel), .op_a(op_a), .op_b(op_b), .oe(oe), .mode64(mode64),
        .flag_clr(flag_clr), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .result(result), .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so)
    );

    typedef struct {
        logic [63:0] res;
        logic [4:0]  fl;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0, n_fail = 0;
    logic [63:0] m_res = '0;
    logic [4:0]  m_fl = '0;   // {so, ov32, ov, ca32, ca}

    task automatic check(input logic [63:0] r, input logic [4:0] f, input exp_t e);
        n_chk++;
        if (r !== e.res || f !== e.fl) begin
            n_fail++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     e.tag, r, f, e.res, e.fl);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected outcome
    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] cs,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic oe_i, input logic m64,
                         input logic clr_i, input logic wr_i, input logic [4:0] wd,
                         input string tag);
        logic [63:0] aa, bb;
        logic        cin, upd, v64, v32, ovn;
        logic [64:0] full, sx65;
        logic [32:0] lo, sx33;
        exp_t        e;
        @(negedge clk);
        op_valid = v; op_code = op; cin_sel = cs; op_a = a; op_b = b;
        oe = oe_i; mode64 = m64; flag_clr = clr_i; flag_wr = wr_i; flag_wdata = wd;
        upd = (op < 3'd6);
        cin = (cs == 2'd1) ? 1'b1 : (cs == 2'd2) ? m_fl[0] : 1'b0;
        case (op)
            3'd0: begin aa = a;  bb = b;   end
            3'd1: begin aa = ~a; bb = b;   end
            3'd2: begin aa = a;  bb = '1;  end
            3'd3: begin aa = ~a; bb = '1;  end
            3'd4: begin aa = a;  bb = '0;  end
            3'd5: begin aa = ~a; bb = '0;  end
            3'd6: begin aa = ~a; bb = '0; cin = 1'b1; end
            default: begin aa = a; bb = b; cin = 1'b0; end
        endcase
        full = {1'b0, aa} + {1'b0, bb} + {64'd0, cin};
        lo   = {1'b0, aa[31:0]} + {1'b0, bb[31:0]} + {32'd0, cin};
        sx65 = {aa[63], aa} + {bb[63], bb} + {64'd0, cin};
        sx33 = {aa[31], aa[31:0]} + {bb[31], bb[31:0]} + {32'd0, cin};
        v64  = sx65[64] ^ sx65[63];
        v32  = sx33[32] ^ sx33[31];
        if (v) m_res = full[63:0];
        if (clr_i) m_fl = '0;
        else if (wr_i) m_fl = wd;
        else if (v) begin
            if (upd) begin
                m_fl[0] = m64 ? full[64] : lo[32];
                m_fl[1] = lo[32];
            end
            if (oe_i) begin
                ovn     = m64 ? v64 : v32;
                m_fl[2] = ovn;
                m_fl[3] = (op == 3'd6) ? ovn : v32;
                m_fl[4] = m_fl[4] | ovn;
            end
        end
        e.res = m_res; e.fl = m_fl; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        drive(1'b0, 3'd7, 2'd0, 64'd0, 64'd0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, "R2 idle hold");
    endtask

    // monitor: compares each registered outcome shortly after the edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(result, {so, ov32, ov, ca32, ca}, e);
            end
        end
    end

    localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] SMAX  = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] SMIN  = 64'h8000_0000_0000_0000;

    initial begin
        exp_t r1;
        repeat (3) @(negedge clk);
        r1.res = '0; r1.fl = '0; r1.tag = "R1 reset state";
        check(result, {so, ov32, ov, ca32, ca}, r1);
        @(negedge clk);
        rst_n = 1'b1;
        // R4: full carry out of bit 63, and low-only carry
        drive(1, 3'd0, 2'd0, ONES, 64'd1, 0, 1, 0, 0, 5'd0, "R4 64-bit carry out");
        drive(1, 3'd0, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 1, 0, 0, 5'd0, "R4 low carry only");
        // R5: 32-bit mode
        drive(1, 3'd0, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 5'd0, "R5 32-bit carry");
        drive(1, 3'd0, 2'd0, 64'hFFFF_FFFF_0000_0000, 64'h1_0000_0000, 0, 0, 0, 0, 5'd0, "R5 high carry ignored");
        // R11: write strobe beats an op
        drive(1, 3'd0, 2'd0, 64'd0, 64'd0, 0, 1, 0, 1, 5'b00001, "R11 write over op");
        // R3: carry-in sources
        drive(1, 3'd0, 2'd2, 64'd5, 64'd6, 0, 1, 0, 0, 5'd0, "R3 cin from ca");
        drive(1, 3'd0, 2'd1, 64'd5, 64'd6, 0, 1, 0, 0, 5'd0, "R3 cin one");
        drive(1, 3'd0, 2'd0, 64'd5, 64'd6, 0, 1, 0, 0, 5'd0, "R3 cin zero");
        drive(1, 3'd0, 2'd3, 64'd5, 64'd6, 0, 1, 0, 0, 5'd0, "R3 cin reserved");
        // R2: subtract-from and extended forms
        drive(1, 3'd1, 2'd1, 64'd3, 64'd10, 0, 1, 0, 0, 5'd0, "R2 subf no borrow");
        drive(1, 3'd1, 2'd1, 64'd10, 64'd3, 0, 1, 0, 0, 5'd0, "R2 subf borrow");
        drive(1, 3'd2, 2'd2, 64'd5, 64'd0, 0, 1, 0, 0, 5'd0, "R2 add-minus-one");
        drive(1, 3'd4, 2'd2, ONES, 64'd0, 0, 1, 0, 0, 5'd0, "R2 add-zero");
        drive(1, 3'd5, 2'd2, 64'd0, 64'd0, 0, 1, 0, 0, 5'd0, "R2 subf-zero");
        drive(1, 3'd3, 2'd2, 64'd0, 64'd0, 0, 1, 0, 0, 5'd0, "R2 subf-minus-one");
        // R6: negate and plain add leave carries
        drive(1, 3'd0, 2'd0, 64'd1, 64'd1, 0, 1, 0, 0, 5'd0, "R6 setup ca=0");
        drive(1, 3'd6, 2'd1, 64'd0, 64'd0, 0, 1, 0, 0, 5'd0, "R6 negate keeps carry");
        drive(1, 3'd7, 2'd1, ONES, 64'd1, 0, 1, 0, 0, 5'd0, "R6 plain add keeps carry");
        // R7/R9: overflow pairs and sticky summary
        drive(1, 3'd0, 2'd0, SMAX, 64'd1, 1, 1, 0, 0, 5'd0, "R7 64-bit overflow");
        drive(1, 3'd0, 2'd0, 64'd1, 64'd1, 1, 1, 0, 0, 5'd0, "R9 so stays set");
        drive(1, 3'd0, 2'd0, 64'h7FFF_FFFF, 64'd1, 1, 0, 0, 0, 5'd0, "R7 32-bit overflow");
        drive(1, 3'd0, 2'd0, 64'h7FFF_FFFF, 64'd1, 1, 1, 0, 0, 5'd0, "R7 low-only overflow");
        // R8: oe low
        drive(1, 3'd0, 2'd0, SMAX, 64'd1, 0, 1, 0, 0, 5'd0, "R8 oe off");
        // R11/R9: clear beats op
        drive(1, 3'd0, 2'd0, SMAX, 64'd1, 1, 1, 1, 0, 5'd0, "R11 clear over op");
        // R10: negate overflow
        drive(1, 3'd6, 2'd0, SMIN, 64'd0, 1, 1, 0, 0, 5'd0, "R10 negate 64-bit min");
        drive(0, 3'd0, 2'd0, 64'd0, 64'd0, 0, 1, 1, 0, 5'd0, "R9 clear strobe");
        drive(1, 3'd6, 2'd0, 64'h8000_0000, 64'd0, 1, 0, 0, 0, 5'd0, "R10 negate 32-bit min");
        drive(0, 3'd0, 2'd0, 64'd0, 64'd0, 0, 1, 1, 0, 5'd0, "R9 clear again");
        drive(1, 3'd6, 2'd0, 64'h8000_0000, 64'd0, 1, 1, 0, 0, 5'd0, "R10 negate low min in 64-bit");
        // R11: clear beats write
        drive(0, 3'd0, 2'd0, 64'd0, 64'd0, 0, 1, 0, 1, 5'h1F, "R11 write all");
        drive(0, 3'd0, 2'd0, 64'd0, 64'd0, 0, 1, 1, 1, 5'h1F, "R11 clear over write");
        idle();
        idle();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule